// File: doc/BRIEF.md
# Source Operand Mode Resolver

This block sits in the decode stage of a 16-bit processor. It takes the 2-bit source addressing mode, the 4-bit source register number, the byte/word flag, the value of that register, the current program counter and the extension word that follows the instruction. It classifies how the source operand is to be obtained: straight from the register, as a hardwired constant, from memory at an address it computes, or as an immediate word fetched at the PC. It also reports whether the extension word is consumed, the PC value after that consumption, and any register post-increment to write back.

Three register numbers change what the four generic modes mean. With the program counter as base, mode 01 becomes PC-relative and mode 11 becomes immediate. With the status register, mode 01 becomes absolute addressing and modes 10 and 11 produce constants. R3 produces a constant in every mode. A constant never causes a memory access or an extension-word fetch.

Requests enter on a valid/ready handshake and results leave on another, through one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every result output holds its value. Flow-through is one cycle: a request taken on edge N shows on the outputs after edge N.

Top module: `srcop_resolver`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs stay unchanged on the next cycle. A result appears one cycle after its request is accepted.
- R2: For mode 00 with a register other than R3, `out_kind` is 0 (register). `out_ea` is 0, no extension word is used, there is no writeback, and `out_pc_next` equals the input PC.
- R3: For mode 01 with a register other than R0, R2 and R3 (indexed), `out_kind` is 2 (memory) and `out_ea` is the register value plus the extension word. The extension word is used and `out_pc_next` is PC+2.
- R4: For mode 10 with a register other than R2 and R3, `out_kind` is 2 and `out_ea` is the register value. No extension word is used and there is no writeback.
- R5: For mode 11 with a register other than R0, R2 and R3, `out_kind` is 2 and `out_ea` is the register value. `out_wb_en` is 1 and `out_wb_reg` is the source register. `out_wb_val` is the register value plus 1 when `in_byte` is 1, or plus 2 when it is 0.
- R6: Mode 01 with R0 (PC) is PC-relative: `out_kind` is 2 and `out_ea` is the input PC (the address of the extension word) plus the extension word. `out_pc_next` is PC+2.
- R7: Mode 01 with R2 is absolute: `out_kind` is 2, `out_ea` is the extension word, and `out_pc_next` is PC+2.
- R8: Mode 11 with R0 is immediate: `out_kind` is 3, `out_ea` is the input PC, and the extension word is used. `out_pc_next` is PC+2 and `out_wb_en` is 0.
- R9: R3 in modes 00, 01, 10 and 11 gives `out_kind` 1 (constant) with `out_const` 0x0000, 0x0001, 0x0002 and 0xFFFF. There is no extension word, no writeback, `out_ea` is 0, and `out_pc_next` is the input PC.
- R10: R2 in mode 10 gives constant 0x0004 and in mode 11 gives constant 0x0008, with no extension word and no writeback.
- R11: When `in_byte` is 1, a constant is output as its low 8 bits with the upper 8 bits zero (so -1 becomes 0x00FF). In all non-constant cases `out_const` is 0.
- R12: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_mode | input | 2 | Source addressing mode |
| in_reg | input | 4 | Source register number |
| in_byte | input | 1 | 1 = byte operation, 0 = word |
| in_reg_val | input | 16 | Value of the source register |
| in_pc | input | 16 | PC, pointing at the extension word slot |
| in_ext_word | input | 16 | Word stored at the PC |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result when high |
| out_kind | output | 2 | 0 register, 1 constant, 2 memory, 3 immediate |
| out_ea | output | 16 | Effective address (memory and immediate kinds) |
| out_ext_used | output | 1 | Extension word consumed |
| out_const | output | 16 | Constant value |
| out_wb_en | output | 1 | Register post-increment writeback |
| out_wb_reg | output | 4 | Register to write back |
| out_wb_val | output | 16 | Incremented register value |
| out_pc_next | output | 16 | PC after the extension word is consumed |

## Verification
The hardest cases to reach are the special-register cases, held under back-pressure. With a uniform register number, R0, R2 and R3 come up in only three requests out of sixteen. The byte-mode constants and the immediate case are rarer still. The random stimulus therefore draws a special register half of the time. It also holds `out_ready` low for a random number of cycles after many results. Directed requests before the random phase cover every constant in both widths, plus the immediate, PC-relative and absolute cases.

// File: rtl/srcop_pkg.sv
package srcop_pkg;
  typedef enum logic [1:0] {
    OPK_REG   = 2'd0,
    OPK_CONST = 2'd1,
    OPK_MEM   = 2'd2,
    OPK_IMM   = 2'd3
  } opkind_e;

  typedef enum logic [2:0] {
    SC_DIRECT, SC_INDEXED, SC_INDIRECT, SC_POSTINC,
    SC_PCREL, SC_ABSOLUTE, SC_IMMED, SC_CONST
  } srcclass_e;

  typedef enum logic [2:0] {
    CK_ZERO, CK_ONE, CK_TWO, CK_FOUR, CK_EIGHT, CK_ALLONES
  } constsel_e;
endpackage

// File: rtl/srcop_classify.sv
module srcop_classify
  import srcop_pkg::*;
#(
  parameter int RW     = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic [1:0]    mode,
  input  logic [RW-1:0] rnum,
  output srcclass_e     cls,
  output constsel_e     csel
);
  logic is_pc, is_sr, is_cg;
  assign is_pc = (rnum == RW'(PC_IDX));
  assign is_sr = (rnum == RW'(SR_IDX));
  assign is_cg = (rnum == RW'(CG_IDX));

  always_comb begin
    cls  = SC_DIRECT;
    csel = CK_ZERO;
    unique case (mode)
      2'b00: begin
        if (is_cg) cls = SC_CONST;
      end
      2'b01: begin
        if (is_pc)      cls = SC_PCREL;
        else if (is_sr) cls = SC_ABSOLUTE;
        else if (is_cg) begin cls = SC_CONST; csel = CK_ONE; end
        else            cls = SC_INDEXED;
      end
      2'b10: begin
        if (is_sr)      begin cls = SC_CONST; csel = CK_FOUR; end
        else if (is_cg) begin cls = SC_CONST; csel = CK_TWO; end
        else            cls = SC_INDIRECT;
      end
      default: begin
        if (is_pc)      cls = SC_IMMED;
        else if (is_sr) begin cls = SC_CONST; csel = CK_EIGHT; end
        else if (is_cg) begin cls = SC_CONST; csel = CK_ALLONES; end
        else            cls = SC_POSTINC;
      end
    endcase
  end
endmodule

// File: rtl/srcop_constgen.sv
module srcop_constgen
  import srcop_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  constsel_e      csel,
  input  logic           byte_op,
  input  logic           active,
  output logic [DW-1:0]  value
);
  localparam logic [DW-1:0] BYTE_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};
  logic [DW-1:0] raw;

  always_comb begin
    unique case (csel)
      CK_ONE:     raw = DW'(1);
      CK_TWO:     raw = DW'(2);
      CK_FOUR:    raw = DW'(4);
      CK_EIGHT:   raw = DW'(8);
      CK_ALLONES: raw = '1;
      default:    raw = '0;
    endcase
  end

  assign value = !active ? '0 : (byte_op ? (raw & BYTE_MASK) : raw);
endmodule

// File: rtl/srcop_addrgen.sv
module srcop_addrgen
  import srcop_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 4
) (
  input  srcclass_e     cls,
  input  logic          byte_op,
  input  logic [RW-1:0] rnum,
  input  logic [DW-1:0] rval,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] ext_word,
  output opkind_e       kind,
  output logic [DW-1:0] ea,
  output logic          ext_used,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_val,
  output logic [DW-1:0] pc_next
);
  localparam logic [DW-1:0] WORD_STEP = DW'(2);
  localparam logic [DW-1:0] BYTE_STEP = DW'(1);

  always_comb begin
    kind     = OPK_MEM;
    ea       = '0;
    ext_used = 1'b0;
    wb_en    = 1'b0;
    wb_reg   = '0;
    wb_val   = '0;
    unique case (cls)
      SC_DIRECT:   kind = OPK_REG;
      SC_CONST:    kind = OPK_CONST;
      SC_INDEXED:  begin ea = rval + ext_word; ext_used = 1'b1; end
      SC_PCREL:    begin ea = pc + ext_word;   ext_used = 1'b1; end
      SC_ABSOLUTE: begin ea = ext_word;        ext_used = 1'b1; end
      SC_INDIRECT: ea = rval;
      SC_POSTINC: begin
        ea     = rval;
        wb_en  = 1'b1;
        wb_reg = rnum;
        wb_val = rval + (byte_op ? BYTE_STEP : WORD_STEP);
      end
      default: begin
        kind     = OPK_IMM;
        ea       = pc;
        ext_used = 1'b1;
      end
    endcase
  end

  assign pc_next = ext_used ? pc + WORD_STEP : pc;
endmodule

// File: rtl/srcop_resolver.sv
module srcop_resolver
  import srcop_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic [RW-1:0] in_reg,
  input  logic          in_byte,
  input  logic [DW-1:0] in_reg_val,
  input  logic [DW-1:0] in_pc,
  input  logic [DW-1:0] in_ext_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [DW-1:0] out_ea,
  output logic          out_ext_used,
  output logic [DW-1:0] out_const,
  output logic          out_wb_en,
  output logic [RW-1:0] out_wb_reg,
  output logic [DW-1:0] out_wb_val,
  output logic [DW-1:0] out_pc_next
);
  localparam int BW = DW / 2;

  srcclass_e     cls;
  constsel_e     csel;
  opkind_e       c_kind;
  logic [DW-1:0] c_ea, c_const, c_wb_val, c_pc_next;
  logic          c_ext, c_wb_en;
  logic [RW-1:0] c_wb_reg;
  logic          take;

  srcop_classify #(.RW(RW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)) u_cls (
    .mode(in_mode), .rnum(in_reg), .cls(cls), .csel(csel)
  );

  srcop_constgen #(.DW(DW), .BW(BW)) u_cg (
    .csel(csel), .byte_op(in_byte), .active(cls == SC_CONST), .value(c_const)
  );

  srcop_addrgen #(.DW(DW), .RW(RW)) u_ag (
    .cls(cls), .byte_op(in_byte), .rnum(in_reg), .rval(in_reg_val), .pc(in_pc),
    .ext_word(in_ext_word), .kind(c_kind), .ea(c_ea), .ext_used(c_ext),
    .wb_en(c_wb_en), .wb_reg(c_wb_reg), .wb_val(c_wb_val), .pc_next(c_pc_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_kind     <= '0;
      out_ea       <= '0;
      out_ext_used <= 1'b0;
      out_const    <= '0;
      out_wb_en    <= 1'b0;
      out_wb_reg   <= '0;
      out_wb_val   <= '0;
      out_pc_next  <= '0;
    end else if (take) begin
      out_kind     <= c_kind;
      out_ea       <= c_ea;
      out_ext_used <= c_ext;
      out_const    <= c_const;
      out_wb_en    <= c_wb_en;
      out_wb_reg   <= c_wb_reg;
      out_wb_val   <= c_wb_val;
      out_pc_next  <= c_pc_next;
    end
  end

  // R1: a stalled result is held
  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea) && $stable(out_kind)
      && $stable(out_const) && $stable(out_pc_next) && $stable(out_wb_val));

  // R1: accepted request shows one cycle later
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R9: constants never fetch or write back
  a_r9_const_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd1 |-> !out_ext_used && !out_wb_en && out_ea == '0);

  // R8: immediate consumes the word at the PC
  a_r8_imm_advance: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 2'd3 |-> out_ext_used && out_pc_next == out_ea + DW'(2));

  // R5: post-increment step is 1 or 2 beyond the address
  a_r5_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wb_en |-> out_kind == 2'd2
      && (out_wb_val - out_ea == DW'(1) || out_wb_val - out_ea == DW'(2)));

  // R11: byte constants have a clear upper half
  a_r11_byte_const: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) && $past(in_byte) |-> out_const[DW-1:BW] == '0);

  // R3: extension word use advances the PC by one word
  a_r3_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) |-> out_pc_next == $past(in_pc) + (out_ext_used ? DW'(2) : DW'(0)));
endmodule

// File: tb/srcop_resolver_tb_top.sv
module srcop_resolver_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0, in_byte = 1'b0, out_ready = 1'b0;
  logic        in_ready, out_valid, out_ext_used, out_wb_en;
  logic [1:0]  in_mode = '0, out_kind;
  logic [3:0]  in_reg = '0, out_wb_reg;
  logic [15:0] in_reg_val = '0, in_pc = '0, in_ext_word = '0;
  logic [15:0] out_ea, out_const, out_wb_val, out_pc_next;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  srcop_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_reg(in_reg), .in_byte(in_byte), .in_reg_val(in_reg_val),
    .in_pc(in_pc), .in_ext_word(in_ext_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_ea(out_ea), .out_ext_used(out_ext_used), .out_const(out_const),
    .out_wb_en(out_wb_en), .out_wb_reg(out_wb_reg), .out_wb_val(out_wb_val),
    .out_pc_next(out_pc_next)
  );

  // {kind, ea, ext, const, wb_en, wb_reg, wb_val, pc_next}
  function automatic logic [71:0] model(input logic [1:0] m, input logic [3:0] r,
      input logic b, input logic [15:0] rv, input logic [15:0] pc, input logic [15:0] xw);
    logic [1:0] k = 2'd2; logic [15:0] ea = 16'h0; logic x = 1'b0; logic [15:0] c = 16'h0;
    logic we = 1'b0; logic [3:0] wr = 4'h0; logic [15:0] wv = 16'h0;
    if (r == 4'd3) begin
      k = 2'd1;
      c = (m == 2'd0) ? 16'h0 : (m == 2'd1) ? 16'h1 : (m == 2'd2) ? 16'h2 : 16'hFFFF;
    end else if (r == 4'd2 && m[1]) begin
      k = 2'd1; c = m[0] ? 16'h8 : 16'h4;
    end else if (m == 2'd0) k = 2'd0;
    else if (m == 2'd1) begin
      x = 1'b1;
      ea = (r == 4'd0) ? pc + xw : (r == 4'd2) ? xw : rv + xw;
    end else if (m == 2'd2) ea = rv;
    else if (r == 4'd0) begin k = 2'd3; ea = pc; x = 1'b1; end
    else begin ea = rv; we = 1'b1; wr = r; wv = rv + (b ? 16'd1 : 16'd2); end
    if (b) c = c & 16'h00FF;
    return {k, ea, x, c, we, wr, wv, x ? pc + 16'd2 : pc};
  endfunction

  function automatic string tag(input logic [1:0] m, input logic [3:0] r, input logic b);
    if (r == 4'd3 || (r == 4'd2 && m[1])) return b ? "R11" : (r == 4'd3 ? "R9" : "R10");
    if (m == 2'd0) return "R2";
    if (m == 2'd1) return r == 4'd0 ? "R6" : (r == 4'd2 ? "R7" : "R3");
    if (m == 2'd2) return "R4";
    return r == 4'd0 ? "R8" : "R5";
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act,
                       input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] m, input logic [3:0] r, input logic b,
      input logic [15:0] rv, input logic [15:0] pc, input logic [15:0] xw, input int stall);
    logic [71:0] exp, act;
    @(negedge clk);
    in_mode = m; in_reg = r; in_byte = b; in_reg_val = rv; in_pc = pc; in_ext_word = xw;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_reg_val = ~rv; in_ext_word = ~xw;
    exp = model(m, r, b, rv, pc, xw);
    act = {out_kind, out_ea, out_ext_used, out_const, out_wb_en, out_wb_reg, out_wb_val,
           out_pc_next};
    check(out_valid && act == exp, tag(m, r, b), act, exp);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      act = {out_kind, out_ea, out_ext_used, out_const, out_wb_en, out_wb_reg, out_wb_val,
             out_pc_next};
      // R1: held under back-pressure, input side not ready
      check(out_valid && !in_ready && act == exp, "R1", act, exp);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R1", 72'(in_ready), 72'(1));
    @(negedge clk);
    check(out_valid == 1'b0, "R1", 72'(out_valid), 72'(0));
    out_ready = 1'b0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12", {out_valid, in_ready}, 72'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12", 72'(out_valid), 72'(0));
    // directed corners
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 4; m++) begin
        run_one(2'(m), 4'd3, b[0], 16'h5A5A, 16'h8000, 16'h1234, 0);   // R9 / R11
        run_one(2'(m), 4'd2, b[0], 16'hA5A5, 16'h8010, 16'hC018, 1);   // R7 / R10
        run_one(2'(m), 4'd0, b[0], 16'h8020, 16'h8020, 16'h000C, 0);   // R6 / R8
        run_one(2'(m), 4'd9, b[0], 16'hFFFF, 16'hFFFE, 16'h0006, 2);   // wrap corner
      end
    end
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [3:0] r;
      r = ($urandom % 2) ? 4'($urandom % 4) : 4'($urandom);
      run_one(2'($urandom), r, 1'($urandom), 16'($urandom), 16'($urandom),
              16'($urandom), int'($urandom % 4));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule